// File: doc/BRIEF.md
# Configurable GPIO Port with Debounced Wake

An eight-pin general-purpose port driven through a small register file. Each pin can be an output, driven from a latch, or an input. A polarity mask flips the sense of the input pins as they are read. One data register covers both cases. Writing it loads the output latch. Reading it returns the latch on output pins and the synchronised, optionally inverted pin level on input pins.

Three fixed pins (0, 1 and 5) can also raise a wake request. Each one passes through its own glitch filter, which counts millisecond ticks and can be bypassed. Each one has a trigger mode: a change of its filtered level, or that level being high. A wake request is held in a sticky status bit. It stays set until the host clears it with a write-one-to-clear access.

Top module: `gpio_wake_port`

## Requirements
- R1: While reset is asserted, and on leaving it, all pins are inputs (`pinOe` = 0x00). The output latch, polarity mask, wake configuration and wake status are zero, `wakeOut` is low, and the direction register reads 0xFF.
- R2: Direction register at address 0. A bit of 1 makes that pin an input and a bit of 0 makes it an output, so `pinOe` is the bitwise inverse of the register. `pinOe` changes only after a write to address 0.
- R3: A write to the data register at address 2 loads the output latch, which drives `pinOut` from the next cycle. `pinOut` changes only after such a write.
- R4: Reading address 2 returns the latch bit for each output pin. For each input pin it returns the pin level after a two-stage synchroniser, XOR the polarity bit. A pin change therefore becomes visible on the second clock edge after it.
- R5: Polarity register at address 1. A bit of 1 inverts that input pin as read and a bit of 0 leaves it unchanged.
- R6: With direction 0xF0 and pins 7:4 looped back from outputs 3:0, writing 0x0A to the data register reads back 0xAA.
- R7: Pins 2, 3, 4, 6 and 7 never set wake status, whatever they do.
- R8: With its filter enabled, a wake pin's filtered level follows a new pin level only after that level has stayed different for 16 consecutive `msTick` pulses. A shorter pulse raises no wake.
- R9: Wake configuration at address 3. Bits 4, 5 and 6 bypass the filter of pins 0, 1 and 5 respectively, and the filtered level then follows the synchronised pin on every clock.
- R10: Bits 0, 1 and 2 of address 3 choose the trigger of pins 0, 1 and 5. With 0, any change of the filtered level sets the status bit. With 1, the status bit is set on every clock while the filtered level is high, so it is set again right after a clear.
- R11: Wake status at address 4 (bit 0 for pin 0, bit 1 for pin 1, bit 2 for pin 5). `wakeOut` is the OR of these bits. A status bit stays set until a write to address 4 with a 1 in that bit. Writing 0 has no effect.
- R12: Addresses 0, 1, 3 and 4 read back the direction, polarity, wake configuration (bits 3 and 7 read 0) and wake status. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr`, combinational |
| pinIn | input | 8 | Pin levels, asynchronous |
| msTick | input | 1 | One-cycle pulse each millisecond |
| pinOut | output | 8 | Output latch values |
| pinOe | output | 8 | Output enables, 1 = drive |
| wakeOut | output | 1 | Wake request, held until cleared |

## Verification
A wrong direction, latch or polarity bit shows on `pinOe`, `pinOut` or the data read in the very cycle after the write. A stuck synchroniser stage delays input reads by one cycle against the reference. A miscounting filter moves the rise of `wakeOut` by whole tick periods, or lets a short glitch through. A wrong pending bit shows on `wakeOut` and on the status read one cycle after the set or clear. The bench compares every output against the reference on every clock, so each of these shows up within a cycle of diverging.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int unsigned PIN_W  = 8;
  localparam int unsigned WAKE_N = 3;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_DIR  = 3'd0,
    RA_INV  = 3'd1,
    RA_DATA = 3'd2,
    RA_CFG  = 3'd3,
    RA_STAT = 3'd4
  } regAddr_e;

  typedef struct packed {
    logic              wrDir;
    logic              wrInv;
    logic              wrData;
    logic              wrCfg;
    logic              clrStat;
    logic [ADDR_W-1:0] rdSel;
  } regStrobe_t;

  // pin number feeding wake source k
  function automatic int unsigned wakePin(input int unsigned k);
    case (k)
      0:       return 0;
      1:       return 1;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/gpio_wake_ctrl.sv
module gpio_wake_ctrl
  import gpio_wake_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        stb
);
  always_comb begin
    stb         = '0;
    stb.rdSel   = addr;
    stb.wrDir   = wrEn && (addr == RA_DIR);
    stb.wrInv   = wrEn && (addr == RA_INV);
    stb.wrData  = wrEn && (addr == RA_DATA);
    stb.wrCfg   = wrEn && (addr == RA_CFG);
    stb.clrStat = wrEn && (addr == RA_STAT);
  end
endmodule

// File: rtl/gpio_wake_deb.sv
module gpio_wake_deb #(
  parameter int unsigned TICKS = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  input  logic bypass,
  input  logic tick,
  output logic filtOut
);
  localparam int unsigned CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cntQ;
  logic             filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      filtQ <= 1'b0;
    end else if (bypass) begin
      cntQ  <= '0;
      filtQ <= rawIn;
    end else if (rawIn == filtQ) begin
      cntQ <= '0;
    end else if (tick) begin
      if (cntQ == LAST) begin
        cntQ  <= '0;
        filtQ <= rawIn;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  assign filtOut = filtQ;
endmodule

// File: rtl/gpio_wake_dp.sv
module gpio_wake_dp
  import gpio_wake_pkg::*;
#(
  parameter int unsigned DEB_TICKS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       stb,
  input  logic [PIN_W-1:0] wrData,
  input  logic [PIN_W-1:0] pinIn,
  input  logic             msTick,
  output logic [PIN_W-1:0] pinOut,
  output logic [PIN_W-1:0] pinOe,
  output logic [PIN_W-1:0] rdData,
  output logic             wakeOut
);
  logic [PIN_W-1:0]  dirQ, invQ, latchQ;
  logic [WAKE_N-1:0] bypassQ, levelQ, pendQ, prevQ, filt, setVec, clrVec;
  logic [SYNC_STAGES-1:0][PIN_W-1:0] syncQ;
  logic [PIN_W-1:0]  pinSync;
  logic              unusedWr;

  assign unusedWr = ^{wrData[7], wrData[3]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ    <= '1;
      invQ    <= '0;
      latchQ  <= '0;
      bypassQ <= '0;
      levelQ  <= '0;
    end else begin
      if (stb.wrDir)  dirQ   <= wrData;
      if (stb.wrInv)  invQ   <= wrData;
      if (stb.wrData) latchQ <= wrData;
      if (stb.wrCfg) begin
        bypassQ <= wrData[6:4];
        levelQ  <= wrData[2:0];
      end
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign pinSync = syncQ[SYNC_STAGES-1];

  generate
    for (genvar k = 0; k < WAKE_N; k++) begin : g_wake
      gpio_wake_deb #(.TICKS(DEB_TICKS)) u_deb (
        .clk    (clk),
        .rstN   (rstN),
        .rawIn  (pinSync[wakePin(k)]),
        .bypass (bypassQ[k]),
        .tick   (msTick),
        .filtOut(filt[k])
      );
      assign setVec[k] = levelQ[k] ? filt[k] : (filt[k] ^ prevQ[k]);
      assign clrVec[k] = stb.clrStat & wrData[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      pendQ <= '0;
    end else begin
      prevQ <= filt;
      pendQ <= setVec | (pendQ & ~clrVec);
    end
  end

  always_comb begin
    case (stb.rdSel)
      RA_DIR:  rdData = dirQ;
      RA_INV:  rdData = invQ;
      RA_DATA: rdData = (latchQ & ~dirQ) | ((pinSync ^ invQ) & dirQ);
      RA_CFG:  rdData = {1'b0, bypassQ, 1'b0, levelQ};
      RA_STAT: rdData = {{(PIN_W-WAKE_N){1'b0}}, pendQ};
      default: rdData = '0;
    endcase
  end

  assign pinOut  = latchQ;
  assign pinOe   = ~dirQ;
  assign wakeOut = |pendQ;
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
#(
  parameter int unsigned DEB_TICKS   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wrData,
  output logic [PIN_W-1:0]  rdData,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic              msTick,
  output logic [PIN_W-1:0]  pinOut,
  output logic [PIN_W-1:0]  pinOe,
  output logic              wakeOut
);
  regStrobe_t stb;

  gpio_wake_ctrl u_ctrl (
    .wrEn(wrEn),
    .addr(addr),
    .stb (stb)
  );

  gpio_wake_dp #(.DEB_TICKS(DEB_TICKS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (wrData),
    .pinIn  (pinIn),
    .msTick (msTick),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .rdData (rdData),
    .wakeOut(wakeOut)
  );
endmodule

// File: rtl/gpio_wake_chk.sv
module gpio_wake_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [2:0] addr,
  input logic [7:0] pinOut,
  input logic [7:0] pinOe,
  input logic       wakeOut
);
  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (pinOe == 8'h00 && pinOut == 8'h00 && !wakeOut));

  a_r2_oe_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd0) |=> $stable(pinOe));

  a_r3_out_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == 3'd2) |=> $stable(pinOut));

  a_r11_wake_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (wakeOut && !(wrEn && addr == 3'd4)) |=> wakeOut);
endmodule

bind gpio_wake_port gpio_wake_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .pinOut (pinOut),
  .pinOe  (pinOe),
  .wakeOut(wakeOut)
);

// File: tb/tb_gpio_wake_port.sv
module tb_gpio_wake_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] pinIn = 8'h00;
  logic       msTick = 1'b0;
  logic [7:0] pinOut, pinOe;
  logic       wakeOut;

  int    testCnt = 0;
  int    failCnt = 0;
  int    cyc = 0;
  bit    tickEn = 0;
  bit    loopEn = 0;
  bit    done = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  gpio_wake_port dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .pinIn(pinIn), .msTick(msTick), .pinOut(pinOut),
    .pinOe(pinOe), .wakeOut(wakeOut)
  );

  // behavioural reference
  logic [7:0] mDir = 8'hFF, mInv = 0, mLat = 0, mS0 = 0, mS1 = 0;
  logic [2:0] mByp = 0, mLvl = 0, mPend = 0;
  bit         mFilt[3] = '{0, 0, 0};
  bit         mPrev[3] = '{0, 0, 0};
  int         mCnt[3]  = '{0, 0, 0};
  int         wp[3]    = '{0, 1, 5};

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mDir = 8'hFF; mInv = 0; mLat = 0; mS0 = 0; mS1 = 0;
      mByp = 0; mLvl = 0; mPend = 0;
      for (int k = 0; k < 3; k++) begin mFilt[k] = 0; mPrev[k] = 0; mCnt[k] = 0; end
    end else begin
      bit nf[3];
      int nc[3];
      logic [2:0] np;
      for (int k = 0; k < 3; k++) begin
        bit setB, clrB, raw;
        setB = mLvl[k] ? mFilt[k] : (mFilt[k] != mPrev[k]);
        clrB = wrEn && addr == 3'd4 && wrData[k];
        np[k] = setB | (mPend[k] & ~clrB);
        raw = mS1[wp[k]];
        nf[k] = mFilt[k]; nc[k] = mCnt[k];
        if (mByp[k]) begin nf[k] = raw; nc[k] = 0; end
        else if (raw == mFilt[k]) nc[k] = 0;
        else if (msTick) begin
          if (mCnt[k] == 15) begin nf[k] = raw; nc[k] = 0; end
          else nc[k] = mCnt[k] + 1;
        end
      end
      for (int k = 0; k < 3; k++) begin
        mPrev[k] = mFilt[k]; mFilt[k] = nf[k]; mCnt[k] = nc[k];
      end
      mPend = np;
      mS1 = mS0; mS0 = pinIn;
      if (wrEn) begin
        case (addr)
          3'd0: mDir = wrData;
          3'd1: mInv = wrData;
          3'd2: mLat = wrData;
          3'd3: begin mByp = wrData[6:4]; mLvl = wrData[2:0]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return mDir;
      3'd1: return mInv;
      3'd2: return (mLat & ~mDir) | ((mS1 ^ mInv) & mDir);
      3'd3: return {1'b0, mByp, 1'b0, mLvl};
      3'd4: return {5'b0, mPend};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (cyc > 0)
      check({tag, " cycle compare"}, {pinOut, pinOe, rdData, 7'b0, wakeOut},
            {mLat, ~mDir, mRead(addr), 7'b0, |mPend});
    cyc++;
    msTick = tickEn && (cyc % 4 == 0);
    if (loopEn) pinIn[7:4] = pinOut[3:0];
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdChk(input string t, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1;
    check(t, rdData, exp);
  endtask

  initial begin
    repeat (3) step();
    check("R1 pinOe in reset", pinOe, 8'h00);
    check("R1 wakeOut in reset", wakeOut, 1'b0);
    rdChk("R1 dir reads FF", 3'd0, 8'hFF);
    rstN = 1'b1;
    step();
    rdChk("R1 status zero", 3'd4, 8'h00);

    tag = "R2";
    wr(3'd0, 8'hF0);
    step();
    check("R2 pinOe inverse of dir", pinOe, 8'h0F);
    rdChk("R12 dir readback", 3'd0, 8'hF0);

    tag = "R6";
    wr(3'd2, 8'h0A);
    loopEn = 1;
    repeat (4) step();
    check("R3 pinOut from latch", pinOut, 8'h0A);
    rdChk("R6 loopback read", 3'd2, 8'hAA);

    tag = "R5";
    wr(3'd1, 8'hF0);
    repeat (2) step();
    rdChk("R5 inverted input bits", 3'd2, 8'h5A);
    rdChk("R12 inv readback", 3'd1, 8'hF0);

    tag = "R9";
    loopEn = 0; pinIn = 8'h00;
    wr(3'd1, 8'h00);
    wr(3'd0, 8'hFF);
    wr(3'd3, 8'h70);
    rdChk("R12 cfg readback", 3'd3, 8'h70);
    repeat (5) step();
    wr(3'd4, 8'h07);
    step();
    check("R11 cleared", wakeOut, 1'b0);
    pinIn[0] = 1'b1;
    repeat (6) step();
    check("R9 bypassed wake on pin0", wakeOut, 1'b1);
    rdChk("R11 status bit0", 3'd4, 8'h01);

    tag = "R11";
    wr(3'd4, 8'h06);
    step();
    check("R11 write 0 to bit keeps wake", wakeOut, 1'b1);
    wr(3'd4, 8'h01);
    check("R11 write 1 clears", wakeOut, 1'b0);

    tag = "R7";
    pinIn = pinIn | 8'hDC;
    repeat (8) step();
    check("R7 other pins rise no wake", wakeOut, 1'b0);
    pinIn = 8'h01;
    repeat (8) step();
    check("R7 other pins fall no wake", wakeOut, 1'b0);
    rdChk("R12 unmapped addr", 3'd6, 8'h00);

    tag = "R8";
    wr(3'd3, 8'h00);
    wr(3'd4, 8'h07);
    tickEn = 1;
    pinIn[5] = 1'b1;
    repeat (20) step();
    pinIn[5] = 1'b0;
    repeat (80) step();
    check("R8 short pulse filtered", wakeOut, 1'b0);
    pinIn[5] = 1'b1;
    repeat (100) step();
    check("R8 long level passes", wakeOut, 1'b1);
    rdChk("R8 status bit2", 3'd4, 8'h04);

    tag = "R10";
    tickEn = 0;
    wr(3'd4, 8'h07);
    wr(3'd3, 8'h72);
    pinIn[1] = 1'b1;
    repeat (6) step();
    rdChk("R10 level sets bit1", 3'd4, 8'h02);
    wr(3'd4, 8'h02);
    repeat (2) step();
    rdChk("R10 level reasserts after clear", 3'd4, 8'h02);
    pinIn[1] = 1'b0;
    repeat (6) step();
    wr(3'd4, 8'h07);
    repeat (3) step();
    rdChk("R10 level low stays clear", 3'd4, 8'h00);

    tag = "R4";
    tickEn = 1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        wrEn = 1'b1;
        addr = 3'($urandom_range(0, 4));
        wrData = 8'($urandom);
      end else begin
        wrEn = 1'b0;
        addr = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 15) == 0) pinIn = 8'($urandom);
      step();
    end
    wrEn = 1'b0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule